// File: doc/BRIEF.md
# Board-Variant Display Control and Card Status Register

This block holds a display-control word and a memory-card status word for a system controller that is built for one of several board variants. The variant comes from a 12-bit board-ID field in bits 27:16 of a 32-bit system-ID parameter. The block resolves that field when the design is elaborated. The variant then fixes four things:

- the reset value of the display word;
- which of its bits software may change;
- whether a write also drives a two-bit pixel-format select output;
- the bit position at which the write-protect pin appears in the card status word.

Software reaches both words through a simple word-addressed register port. A write takes effect on the clock edge where the write strobe is high. A read returns the addressed word on the clock edge where the read strobe is high, and the read data holds that value until the next read. The card-detect and write-protect pins are sampled every clock into the status word.

Top module: `sysctl_disp_regs`

## Requirements
- R1: The board ID is bits 27:16 of the `SYS_ID` parameter, and bits 31:28 and 15:0 have no effect. ID 0x100 is the muxed early board. ID 0x140 is the plain early board. IDs 0x178 and 0x182 are late boards. ID 0x190 is the board without a display word. Any other ID is an unrecognised board.
- R2: Reset is asynchronous, active low, and released synchronously. After reset the display word reads 0x0000_1F00 on every board except 0x190, `fmt_sel` is 0, and `rd_data` is 0.
- R3: On board 0x190 the display word (offset 0x50) always reads zero, and writes to it are ignored.
- R4: On boards 0x100 and 0x140 a write to offset 0x50 leaves bits 13:8 unchanged and loads every other bit from `wr_data`.
- R5: On board 0x100 each write to offset 0x50 puts `wr_data[1:0]` on `fmt_sel` from the next clock, and `fmt_sel` holds that value until the next such write. On every other board `fmt_sel` stays 0.
- R6: On boards 0x178 and 0x182 a write to offset 0x50 keeps bit 7 of the display word and loads every other bit from `wr_data`.
- R7: The card status word reads at offset 0x48. Bit 0 holds `card_det`. `wr_prot` sits at bit 2 on boards 0x100 and 0x140 and at bit 1 on all other boards. Every other bit is zero. The pins are sampled on each clock edge, so a read issued one cycle after a pin change returns the new value.
- R8: On a clock edge with `rd_en` high, `rd_data` loads the addressed word, and offsets other than 0x48 and 0x50 read zero. `rd_data` holds its value while `rd_en` is low. Writes to offsets other than 0x50 change nothing.
- R9: On an unrecognised board the display word keeps its reset value 0x1F00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| card_det | input | 1 | Card-present pin |
| wr_prot | input | 1 | Card write-protect pin |
| fmt_sel | output | FMT_W | Pixel-format select, driven on board 0x100 only |

## Verification
Six copies of the block, one per board kind, run side by side. Two of them use late IDs, and one uses an unrecognised ID. Their system-ID words set bits outside 27:16, so a design that decoded the wrong field would treat a board as the wrong variant.

The bench writes all-ones, all-zeros and random patterns to catch the following faults:

- a hold mask placed on the wrong bits, which would let bits 13:8 or bit 7 change;
- a write that leaks into the word on board 0x190 or on the unrecognised board;
- a `fmt_sel` that moves on the wrong board or on a write to another offset.

Every combination of the two pins is read back, which exposes a write-protect bit placed at the wrong position for the variant. Reads of unmapped offsets, and idle cycles after a read, show whether `rd_data` returns zero and then holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int BOARD_ID_LSB = 16;
  localparam int BOARD_ID_W   = 12;

  localparam logic [31:0] DISP_RESET_VAL = 32'h0000_1F00;
  localparam logic [31:0] EARLY_RO_MASK  = 32'h0000_3F00;
  localparam logic [31:0] LATE_KEEP_MASK = 32'h0000_0080;

  typedef enum logic [2:0] {
    BK_MUXED   = 3'd0,
    BK_EARLY   = 3'd1,
    BK_LATE    = 3'd2,
    BK_NODISP  = 3'd3,
    BK_UNKNOWN = 3'd4
  } board_kind_e;

  function automatic board_kind_e kind_of(input logic [31:0] sys_id);
    logic [BOARD_ID_W-1:0] id;
    id = sys_id[BOARD_ID_LSB +: BOARD_ID_W];
    case (id)
      12'h100:         return BK_MUXED;
      12'h140:         return BK_EARLY;
      12'h178, 12'h182: return BK_LATE;
      12'h190:         return BK_NODISP;
      default:         return BK_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/disp_ctl_reg.sv
module disp_ctl_reg
  import sysctl_pkg::*;
#(
  parameter board_kind_e KIND   = BK_MUXED,
  parameter int          DATA_W = 32,
  parameter int          FMT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] disp_val,
  output logic [FMT_W-1:0]  fmt_sel
);

  localparam bit IS_EARLY  = (KIND == BK_MUXED) || (KIND == BK_EARLY);
  localparam bit WR_ACTIVE = IS_EARLY || (KIND == BK_LATE);
  localparam logic [DATA_W-1:0] HOLD_MASK =
      IS_EARLY          ? DATA_W'(EARLY_RO_MASK)  :
      (KIND == BK_LATE) ? DATA_W'(LATE_KEEP_MASK) : '1;
  localparam logic [DATA_W-1:0] RESET_VAL =
      (KIND == BK_NODISP) ? '0 : DATA_W'(DISP_RESET_VAL);

  logic [DATA_W-1:0] disp_q, disp_d;
  logic              disp_en;

  always_comb begin
    disp_en = wr_hit && WR_ACTIVE;
    disp_d  = (disp_q & HOLD_MASK) | (wr_data & ~HOLD_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disp_q <= RESET_VAL;
    else if (disp_en) disp_q <= disp_d;
  end

  assign disp_val = disp_q;

  generate
    if (KIND == BK_MUXED) begin : g_fmt
      logic [FMT_W-1:0] fmt_q, fmt_d;
      logic             fmt_en;

      always_comb begin
        fmt_en = wr_hit;
        fmt_d  = wr_data[FMT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fmt_q <= '0;
        else if (fmt_en) fmt_q <= fmt_d;
      end

      assign fmt_sel = fmt_q;

      a_r5_fmt_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> fmt_sel == $past(wr_data[FMT_W-1:0]));
      a_r5_fmt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(fmt_sel));
    end else begin : g_no_fmt
      assign fmt_sel = '0;
    end

    if (IS_EARLY) begin : g_chk_early
      a_r4_ro_field_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(disp_q[13:8]));
      a_r4_low_bits_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> disp_q[7:0] == $past(wr_data[7:0]));
    end

    if (KIND == BK_LATE) begin : g_chk_late
      a_r6_bit7_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> disp_q[7] == $past(disp_q[7]));
      a_r6_others_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> disp_q[6:0] == $past(wr_data[6:0]));
    end

    if (!WR_ACTIVE) begin : g_chk_frozen
      a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> $stable(disp_q));
    end
  endgenerate

endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
  import sysctl_pkg::*;
#(
  parameter board_kind_e KIND   = BK_MUXED,
  parameter int          DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_det,
  input  logic              wr_prot,
  output logic [DATA_W-1:0] stat_val
);

  localparam int WP_BIT = ((KIND == BK_MUXED) || (KIND == BK_EARLY)) ? 2 : 1;

  logic [DATA_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              armed_q;

  always_comb begin
    stat_en        = 1'b1;
    stat_d         = '0;
    stat_d[0]      = card_det;
    stat_d[WP_BIT] = wr_prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign stat_val = stat_q;

  a_r7_card_bit: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> stat_q[0] == $past(card_det));
  a_r7_wp_bit: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> stat_q[WP_BIT] == $past(wr_prot));
  a_r7_at_most_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_q) <= 2);

endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] DISP_OFS = 12'h050,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] disp_val,
  input  logic [DATA_W-1:0] stat_val,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_load;

  always_comb begin
    rd_load = rd_en;
    if (addr == DISP_OFS)      rd_d = disp_val;
    else if (addr == STAT_OFS) rd_d = stat_val;
    else                       rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != DISP_OFS && addr != STAT_OFS) |=> rd_data == '0);
  a_r8_disp_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == DISP_OFS) |=> rd_data == $past(disp_val));

endmodule

// File: rtl/sysctl_disp_regs.sv
module sysctl_disp_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] SYS_ID   = 32'h0100_0000,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          FMT_W    = 2,
  parameter logic [ADDR_W-1:0] DISP_OFS = 12'h050,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              card_det,
  input  logic              wr_prot,
  output logic [FMT_W-1:0]  fmt_sel
);

  localparam board_kind_e KIND = kind_of(SYS_ID);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              wr_hit;
  logic [DATA_W-1:0] disp_val;
  logic [DATA_W-1:0] stat_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];
  assign wr_hit     = wr_en && (addr == DISP_OFS);

  disp_ctl_reg #(
    .KIND   (KIND),
    .DATA_W (DATA_W),
    .FMT_W  (FMT_W)
  ) u_disp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (wr_hit),
    .wr_data  (wr_data),
    .disp_val (disp_val),
    .fmt_sel  (fmt_sel)
  );

  card_status_reg #(
    .KIND   (KIND),
    .DATA_W (DATA_W)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .card_det (card_det),
    .wr_prot  (wr_prot),
    .stat_val (stat_val)
  );

  sysctl_rd_mux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DISP_OFS (DISP_OFS),
    .STAT_OFS (STAT_OFS)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .disp_val (disp_val),
    .stat_val (stat_val),
    .rd_data  (rd_data)
  );

  generate
    if (KIND == BK_NODISP) begin : g_chk_nodisp
      a_r3_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (rd_en && addr == DISP_OFS) |=> rd_data == '0);
    end
    if (KIND != BK_MUXED) begin : g_chk_no_fmt
      a_r5_fmt_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
        fmt_sel == '0);
    end
  endgenerate

endmodule

// File: tb/test_sysctl_disp_regs.sv
module test_sysctl_disp_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 6;

  function automatic logic [31:0] sid_of(input int k);
    case (k)
      0:       return 32'h3100_1234;
      1:       return 32'hC140_0F0F;
      2:       return 32'h0178_0000;
      3:       return 32'h7182_FFFF;
      4:       return 32'h9190_0001;
      default: return 32'h2ABC_0000;
    endcase
  endfunction

  // 0: 0x100, 1: 0x140, 2: late, 3: 0x190, 4: unknown
  function automatic int kind_m(input int k);
    logic [11:0] id;
    id = sid_of(k)[27:16];
    case (id)
      12'h100: return 0;
      12'h140: return 1;
      12'h178, 12'h182: return 2;
      12'h190: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] m_reset(input int k);
    return (kind_m(k) == 3) ? 32'h0 : 32'h1F00;
  endfunction

  function automatic logic [31:0] m_write(input int k, input logic [31:0] cur,
                                          input logic [31:0] wd);
    case (kind_m(k))
      0, 1:    return (cur & 32'h3F00) | (wd & ~32'h3F00);
      2:       return (cur & 32'h80) | (wd & ~32'h80);
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] m_stat(input int k, input logic cd, input logic wp);
    logic [31:0] v;
    v = 32'h0;
    v[0] = cd;
    if (kind_m(k) <= 1) v[2] = wp;
    else                v[1] = wp;
    return v;
  endfunction

  logic        clk, rst_n, wr_en, rd_en, card_det, wr_prot;
  logic [11:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_w  [NB];
  logic [1:0]  fmt_w [NB];

  logic [31:0] m_disp [NB];
  logic [1:0]  m_fmt  [NB];
  logic [31:0] m_rd   [NB];

  int n_checks = 0;
  int n_fail   = 0;

  for (genvar g = 0; g < NB; g++) begin : g_brd
    sysctl_disp_regs #(.SYS_ID(sid_of(g))) i_sysctl_disp_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_w[g]),
      .card_det (card_det),
      .wr_prot  (wr_prot),
      .fmt_sel  (fmt_w[g])
    );
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int k, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s board%0d actual=%h expected=%h", req, k, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic chk_fmt(input string req);
    for (int k = 0; k < NB; k++) chk(req, k, {30'h0, fmt_w[k]}, {30'h0, m_fmt[k]});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 12'h050) begin
      for (int k = 0; k < NB; k++) begin
        m_disp[k] = m_write(k, m_disp[k], d);
        if (kind_m(k) == 0) m_fmt[k] = d[1:0];
      end
    end
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    for (int k = 0; k < NB; k++) begin
      if (a == 12'h050)      m_rd[k] = m_disp[k];
      else if (a == 12'h048) m_rd[k] = m_stat(k, card_det, wr_prot);
      else                   m_rd[k] = 32'h0;
      chk(req, k, rd_w[k], m_rd[k]);
    end
  endtask

  task automatic set_pins(input logic cd, input logic wp);
    @(negedge clk);
    card_det = cd; wr_prot = wp;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [11:0] ra;
    int op;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    card_det = 1'b0; wr_prot = 1'b0;
    for (int k = 0; k < NB; k++) begin
      m_disp[k] = m_reset(k); m_fmt[k] = 2'b00; m_rd[k] = 32'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state of outputs and of the display word
    for (int k = 0; k < NB; k++) chk("R2 rd_data reset", k, rd_w[k], 32'h0);
    chk_fmt("R2 fmt_sel reset");
    do_read(12'h050, "R2 R1 R3 display reset value");
    do_read(12'h048, "R7 status after reset");

    // R4 R6 R3 R9: all ones, then all zeros
    do_write(12'h050, 32'hFFFF_FFFF);
    chk_fmt("R5 fmt after all-ones write");
    do_read(12'h050, "R4 R6 R3 R9 all-ones write");
    do_write(12'h050, 32'h0000_0000);
    chk_fmt("R5 fmt after zero write");
    do_read(12'h050, "R4 R6 R3 R9 zero write");

    // R5: mux value holds over idle cycles and over other writes
    do_write(12'h050, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk_fmt("R5 fmt holds while idle");
    do_write(12'h054, 32'hFFFF_FFFF);
    chk_fmt("R5 fmt unaffected by other offset");
    do_read(12'h050, "R8 write to other offset ignored");

    // R7: every pin combination
    for (int p = 0; p < 4; p++) begin
      set_pins(p[0], p[1]);
      do_read(12'h048, "R7 pin combination");
    end

    // R8: unmapped read returns zero, then rd_data holds
    do_read(12'h3FC, "R8 unmapped read");
    do_read(12'h050, "R8 display read");
    repeat (3) @(negedge clk);
    for (int k = 0; k < NB; k++) chk("R8 rd_data holds", k, rd_w[k], m_rd[k]);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      op = $urandom % 6;
      case (op)
        0, 1: do_write(12'h050, $urandom);
        2:    do_read(12'h050, "R4 R6 R3 R9 random display");
        3: begin
          set_pins(1'($urandom), 1'($urandom));
          do_read(12'h048, "R7 random pins");
        end
        4, 5: begin
          ra = {10'($urandom), 2'b00};
          if (ra == 12'h050 || ra == 12'h048) ra = 12'h054;
          if (op == 4) do_write(ra, $urandom);
          else         do_read(ra, "R8 random unmapped read");
        end
        default: ;
      endcase
      chk_fmt("R5 random fmt");
    end
    do_read(12'h050, "R4 R6 R3 R9 final display");
    summary();
  end

endmodule